// File: doc/BRIEF.md
# Four-Group Carry Lookahead Generator

This block speeds up addition over wide words built from 4-bit adder or ALU slices. Each slice reports a group propagate and group generate pair. The generator combines these pairs with a carry input and returns, in one combinational step, the carries into groups 1, 2 and 3. No signal ripples through the slices themselves.

The block also produces a block-level propagate and generate pair. This pair has the same polarity and meaning as one slice's pair. It can therefore feed one input position of another identical generator, which builds a second level of lookahead: sixteen slices become one 64-bit adder. The carry out of a whole block is not an output. It is formed outside the block from the block pair and the carry input.

The pin polarities are fixed. Propagate and generate pins are active low on both inputs and outputs. The carry input and the carry outputs are active high. Below, "asserted" means the active level: low for a propagate or generate pin, high for a carry pin. The group count is a parameter, and the default is four groups.

Top module: `cla_gen4`

## Requirements
- R1: `carry_o[0]` (the carry into group 1) is high when `g_ni[0]` is asserted, or when `p_ni[0]` is asserted and `cin_i` is high; otherwise it is low.
- R2: `carry_o[1]` (the carry into group 2) is high when group 1 generates, or group 1 propagates and group 0 generates, or groups 1 and 0 both propagate and `cin_i` is high.
- R3: `carry_o[2]` (the carry into group 3) is high when group 2 generates, or when a generate in group 1 or group 0 is propagated by every group above it up to group 2, or when groups 0, 1 and 2 all propagate and `cin_i` is high.
- R4: `blk_g_no` is low exactly when group 3 generates, or when a generate in a lower group is propagated by every group above it up to group 3. The value of `cin_i` never changes `blk_g_no`.
- R5: `blk_p_no` is low exactly when all four `p_ni` bits are low. The value of `cin_i` never changes `blk_p_no`.
- R6: Four 4-bit slices joined by one generator add two 16-bit operands and a carry-in correctly. In each slice, the group generates when the two nibbles sum to 16 or more, and propagates when they sum to 15 or more. The carry out of the whole word equals `!blk_g_no | (!blk_p_no & cin_i)`.
- R7: When the `blk_p_no`/`blk_g_no` outputs of four generators feed a fifth generator, and the fifth generator's carries drive the lower generators' `cin_i`, sixteen slices add two 64-bit operands correctly, including the final carry out.
- R8: Consider any input in which every asserted generate also has its propagate asserted. Apply the dual input: each `p_ni` bit is replaced by the complement of the same group's `g_ni` bit, each `g_ni` bit by the complement of the `p_ni` bit, and `cin_i` by its complement. Every bit of `carry_o` is then the complement of its original value. This is what lets the same wiring serve active-low operand slices.
- R9: With every propagate and generate deasserted (all pins high) and `cin_i` low, `carry_o` is 0 and both `blk_p_no` and `blk_g_no` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cin_i | input | 1 | Carry into group 0, active high |
| p_ni | input | 4 | Group propagate per slice, active low |
| g_ni | input | 4 | Group generate per slice, active low |
| carry_o | output | 3 | Carries into groups 1..3, active high |
| blk_p_no | output | 1 | Block propagate, active low |
| blk_g_no | output | 1 | Block generate, active low |

## Verification
The checker tests the local implications on every input change:
- a generate forces the carry just above it;
- an asserted propagate carries the carry below it upward;
- a group that neither generates nor propagates kills its carry;
- a top-group generate drives the block generate;
- full propagation with no generate makes every carry follow `cin_i`.

Some properties only the bench scenarios can show. These are the exact value of each output over all 512 input patterns, the independence of the block pair from `cin_i`, the polarity duality, and correct sums from the one-level 16-bit adder and the two-level 64-bit adder.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned CLA_GROUPS_DEF = 4;

  // asserted-sense AND of v[lo..hi]; empty range yields 1
  function automatic logic span_and(input logic [31:0] v, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int m = 0; m < 32; m++) begin
      if (m >= lo && m <= hi) r = r & v[m];
    end
    return r;
  endfunction
endpackage

// File: rtl/cla_pol_in.sv
module cla_pol_in #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] pin_ni,
  output logic [W-1:0] asserted_o
);
  assign asserted_o = ~pin_ni;
endmodule

// File: rtl/cla_carry_sop.sv
module cla_carry_sop #(
  parameter int unsigned NC = 3
) (
  input  logic          cin_i,
  input  logic [NC-1:0] p_i,
  input  logic [NC-1:0] g_i,
  output logic [NC-1:0] c_o
);
  import cla_pkg::*;

  logic [31:0] p_w, g_w;
  assign p_w = 32'(p_i);
  assign g_w = 32'(g_i);

  for (genvar k = 0; k < NC; k++) begin : g_carry
    // flat sum of products: each term spans one generate plus the propagates above it
    always_comb begin
      logic acc;
      acc = cin_i & span_and(p_w, 0, k);
      for (int j = 0; j <= k; j++) begin
        acc = acc | (g_w[j] & span_and(p_w, j + 1, k));
      end
      c_o[k] = acc;
    end
  end
endmodule

// File: rtl/cla_block_pg.sv
module cla_block_pg #(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] p_i,
  input  logic [NG-1:0] g_i,
  output logic          blk_p_o,
  output logic          blk_g_o
);
  import cla_pkg::*;

  logic [31:0] p_w, g_w;
  logic [NG-1:0] term;
  assign p_w = 32'(p_i);
  assign g_w = 32'(g_i);

  for (genvar j = 0; j < NG; j++) begin : g_term
    assign term[j] = g_w[j] & span_and(p_w, j + 1, NG - 1);
  end

  assign blk_g_o = |term;
  assign blk_p_o = &p_i;
endmodule

// File: rtl/cla_gen4.sv
module cla_gen4 #(
  parameter int unsigned N_GROUPS = cla_pkg::CLA_GROUPS_DEF,
  localparam int unsigned NC = N_GROUPS - 1
) (
  input  logic                cin_i,
  input  logic [N_GROUPS-1:0] p_ni,
  input  logic [N_GROUPS-1:0] g_ni,
  output logic [NC-1:0]       carry_o,
  output logic                blk_p_no,
  output logic                blk_g_no
);
  logic [N_GROUPS-1:0] p_a, g_a;
  logic blk_p, blk_g;

  cla_pol_in #(.W(N_GROUPS)) u_p_in (.pin_ni(p_ni), .asserted_o(p_a));
  cla_pol_in #(.W(N_GROUPS)) u_g_in (.pin_ni(g_ni), .asserted_o(g_a));

  // top group only feeds the block pair
  cla_carry_sop #(.NC(NC)) u_carry (
    .cin_i (cin_i),
    .p_i   (p_a[NC-1:0]),
    .g_i   (g_a[NC-1:0]),
    .c_o   (carry_o)
  );

  cla_block_pg #(.NG(N_GROUPS)) u_blk (
    .p_i     (p_a),
    .g_i     (g_a),
    .blk_p_o (blk_p),
    .blk_g_o (blk_g)
  );

  assign blk_p_no = ~blk_p;
  assign blk_g_no = ~blk_g;
endmodule

// File: rtl/cla_gen4_chk.sv
module cla_gen4_chk #(
  parameter int unsigned NG = 4
) (
  input logic          cin_i,
  input logic [NG-1:0] p_ni,
  input logic [NG-1:0] g_ni,
  input logic [NG-2:0] carry_o,
  input logic          blk_p_no,
  input logic          blk_g_no
);
  always_comb begin
    if (!g_ni[0]) p_gen_cx_r1: assert (carry_o[0]);
    if (p_ni[0] && g_ni[0]) p_kill_cx_r1: assert (!carry_o[0]);
    if (!p_ni[1] && carry_o[0]) p_prop_cy_r2: assert (carry_o[1]);
    if (!g_ni[1]) p_gen_cy_r2: assert (carry_o[1]);
    if (!p_ni[2] && carry_o[1]) p_prop_cz_r3: assert (carry_o[2]);
    if (p_ni[2] && g_ni[2]) p_kill_cz_r3: assert (!carry_o[2]);
    if (!g_ni[3]) p_gen_blk_r4: assert (!blk_g_no);
    if (!blk_p_no && (&g_ni)) p_follow_cin_r5: assert (carry_o == {(NG-1){cin_i}});
    if ((&p_ni) && (&g_ni) && !cin_i)
      p_idle_r9: assert (carry_o == '0 && blk_p_no && blk_g_no);
  end
endmodule

bind cla_gen4 cla_gen4_chk #(.NG(N_GROUPS)) u_chk (
  .cin_i    (cin_i),
  .p_ni     (p_ni),
  .g_ni     (g_ni),
  .carry_o  (carry_o),
  .blk_p_no (blk_p_no),
  .blk_g_no (blk_g_no)
);

// File: tb/tb_cla_gen4.sv
`timescale 1ns/1ps
module tb_cla_gen4;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       cin;
  logic [3:0] p_n, g_n;
  logic [2:0] carry;
  logic       bp_n, bg_n;

  cla_gen4 dut (.cin_i(cin), .p_ni(p_n), .g_ni(g_n), .carry_o(carry),
                .blk_p_no(bp_n), .blk_g_no(bg_n));

  // two-level 64-bit structure
  logic [15:0] p64_n, g64_n;
  logic [3:0]  lv_cin, lv_bp_n, lv_bg_n;
  logic [11:0] lv_c;
  logic        cin64;
  logic [2:0]  top_c;
  logic        top_bp_n, top_bg_n;

  for (genvar i = 0; i < 4; i++) begin : g_lv
    cla_gen4 u_lv (.cin_i(lv_cin[i]), .p_ni(p64_n[4*i+3:4*i]), .g_ni(g64_n[4*i+3:4*i]),
                   .carry_o(lv_c[3*i+2:3*i]), .blk_p_no(lv_bp_n[i]), .blk_g_no(lv_bg_n[i]));
  end
  cla_gen4 u_top (.cin_i(cin64), .p_ni(lv_bp_n), .g_ni(lv_bg_n), .carry_o(top_c),
                  .blk_p_no(top_bp_n), .blk_g_no(top_bg_n));
  assign lv_cin = {top_c, cin64};

  // behavioural reference: ripple in asserted sense
  function automatic logic [4:0] ref_cla(input logic [3:0] pn, input logic [3:0] gn, input logic ci);
    logic c; logic [2:0] cs; logic bg;
    c = ci;
    for (int k = 0; k < 3; k++) begin
      c = !gn[k] | (!pn[k] & c);
      cs[k] = c;
    end
    bg = 1'b0;
    for (int k = 0; k < 4; k++) bg = !gn[k] | (!pn[k] & bg);
    return {cs, ~(pn == 4'h0), ~bg};
  endfunction

  function automatic logic [1:0] slice_pg(input logic [3:0] a, input logic [3:0] b);
    int s;
    s = int'(a) + int'(b);
    return {~(s >= 15), ~(s >= 16)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] pn, input logic [3:0] gn, input logic ci);
    @(posedge clk);
    p_n = pn; g_n = gn; cin = ci;
    @(negedge clk);
  endtask

  task automatic add16(input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic [1:0] pg; logic [15:0] s; logic [16:0] exp; logic c, co;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      pg = slice_pg(a[4*k+:4], b[4*k+:4]);
      p_n[k] = pg[1]; g_n[k] = pg[0];
    end
    cin = ci;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      c = (k == 0) ? ci : carry[k-1];
      s[4*k+:4] = a[4*k+:4] + b[4*k+:4] + {3'b0, c};
    end
    co = !bg_n | (!bp_n & ci);
    exp = {1'b0, a} + {1'b0, b} + {16'b0, ci};
    check("R6 add16", {47'b0, co, s}, {47'b0, exp});
  endtask

  task automatic add64(input logic [63:0] a, input logic [63:0] b, input logic ci);
    logic [1:0] pg; logic [63:0] s; logic c, co; logic [64:0] exp;
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      pg = slice_pg(a[4*k+:4], b[4*k+:4]);
      p64_n[k] = pg[1]; g64_n[k] = pg[0];
    end
    cin64 = ci;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      c = (k % 4 == 0) ? lv_cin[k/4] : lv_c[3*(k/4) + (k%4) - 1];
      s[4*k+:4] = a[4*k+:4] + b[4*k+:4] + {3'b0, c};
    end
    co = !top_bg_n | (!top_bp_n & ci);
    exp = {1'b0, a} + {1'b0, b} + {64'b0, ci};
    check("R7 add64 low", s, exp[63:0]);
    check("R7 add64 cout", {63'b0, co}, {63'b0, exp[64]});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] r, r2;
    logic [2:0] c0;
    p_n = 4'hf; g_n = 4'hf; cin = 1'b0;
    p64_n = '1; g64_n = '1; cin64 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 idle", {58'b0, carry, bp_n, bg_n}, {58'b0, 3'b000, 1'b1, 1'b1});

    // exhaustive sweep
    for (int v = 0; v < 512; v++) begin
      apply(v[3:0], v[7:4], v[8]);
      r = ref_cla(v[3:0], v[7:4], v[8]);
      check("R1 cx", {63'b0, carry[0]}, {63'b0, r[2]});
      check("R2 cy", {63'b0, carry[1]}, {63'b0, r[3]});
      check("R3 cz", {63'b0, carry[2]}, {63'b0, r[4]});
      check("R4 blk_g", {63'b0, bg_n}, {63'b0, r[0]});
      check("R5 blk_p", {63'b0, bp_n}, {63'b0, r[1]});
    end

    // block pair ignores cin
    for (int v = 0; v < 256; v++) begin
      logic a_p, a_g;
      apply(v[3:0], v[7:4], 1'b0);
      a_p = bp_n; a_g = bg_n;
      apply(v[3:0], v[7:4], 1'b1);
      check("R4 cin-indep", {63'b0, bg_n}, {63'b0, a_g});
      check("R5 cin-indep", {63'b0, bp_n}, {63'b0, a_p});
    end

    // polarity duality where every generate implies its propagate
    for (int v = 0; v < 512; v++) begin
      if ((~v[7:4] & v[3:0]) == 4'h0) begin
        apply(v[3:0], v[7:4], v[8]);
        c0 = carry;
        apply(~v[7:4], ~v[3:0], ~v[8]);
        check("R8 dual", {61'b0, carry}, {61'b0, ~c0});
      end
    end

    // one-level 16-bit adder
    add16(16'h0000, 16'h0000, 1'b0);
    add16(16'hffff, 16'h0001, 1'b0);
    add16(16'hffff, 16'h0000, 1'b1);
    add16(16'hffff, 16'hffff, 1'b1);
    add16(16'h0f0f, 16'h00f1, 1'b0);
    for (int i = 0; i < 300; i++) add16(16'($urandom), 16'($urandom), 1'($urandom));

    // two-level 64-bit adder
    add64(64'hffff_ffff_ffff_ffff, 64'h1, 1'b0);
    add64(64'hffff_ffff_ffff_ffff, 64'h0, 1'b1);
    add64(64'h0, 64'h0, 1'b0);
    add64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);
    for (int i = 0; i < 300; i++)
      add64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));

    // idle again after traffic
    apply(4'hf, 4'hf, 1'b0);
    r2 = ref_cla(4'hf, 4'hf, 1'b0);
    check("R9 idle again", {59'b0, carry, bp_n, bg_n}, {59'b0, r2});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule